// File: doc/BRIEF.md
# Four-Wire Resistive Touch Scan Sequencer

This block runs a four-wire resistive touch panel through tri-state electrode drivers and an external analog-to-digital converter. A free-running scan timer starts a scan once per period. Each scan measures the horizontal axis and then the vertical axis. For an axis, one electrode pair is driven to supply and ground while the other pair floats. The block waits for the panel to settle, pulses a conversion request, and waits for the converter to report that the sample is ready.

Each 10-bit raw sample goes into a per-axis three-tap median filter. This removes isolated spikes before the coordinate reaches the host logic. A one-cycle strobe marks a fresh coordinate pair only when both axes were converted within the same scan. A converter that never answers aborts the scan and raises an error flag. The flag stays set until a later scan completes.

Electrode bits use this order on both drive buses: bit 0 is X+, bit 1 is X-, bit 2 is Y+, bit 3 is Y-. An enable bit at 0 floats that electrode. The level bit then has no effect.

Top module: `touch_scan_seq`

## Requirements
- R1: During a horizontal measurement, drive enables are 4'b0011 and drive levels are 4'b0001 (X+ high, X- low, Y pair floating), and the sense select is 0 (sample Y+).
- R2: During a vertical measurement, drive enables are 4'b1100 and drive levels are 4'b0100 (Y+ high, Y- low, X pair floating), and the sense select is 1 (sample X+).
- R3: After every change of electrode drive, the conversion request rises exactly SETTLE_CYC cycles later. The drive stays unchanged until that conversion ends.
- R4: The horizontal excitation of successive scans begins at multiples of PERIOD_CYC cycles apart.
- R5: The conversion request is a single-cycle pulse. A done flag is only accepted in the cycles after the request. A done flag while no conversion is pending changes no output.
- R6: If no done flag arrives within TIMEOUT_CYC cycles after the request cycle, the scan aborts. All electrodes float, the error flag is set, and no valid strobe is raised.
- R7: A done flag arriving in the last cycle of the timeout window is accepted and the timeout is not taken.
- R8: Once an axis has three samples since reset, its output is the median of its three newest samples.
- R9: Until an axis holds three samples since reset, its output equals its newest sample.
- R10: The valid strobe is high for one cycle, in the same cycle that both new axis values appear. It only follows a scan in which both axes converted.
- R11: The error flag clears in the same cycle as the next valid strobe.
- R12: During reset and between scans all electrodes float. After reset, the coordinate outputs, the strobe, the request and the error flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elec_drv_en | output | 4 | Per-electrode drive enable (0 floats) |
| elec_drv_hi | output | 4 | Per-electrode drive level (1 supply, 0 ground) |
| sense_on_xp | output | 1 | Sense electrode select: 1 X+, 0 Y+ |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Converter result ready |
| adc_data | input | 10 | Converter result, codes 0 to 1023 |
| x_pos | output | 10 | Filtered horizontal coordinate |
| y_pos | output | 10 | Filtered vertical coordinate |
| pos_valid | output | 1 | One-cycle strobe for a new coordinate pair |
| adc_err | output | 1 | Set by a conversion timeout, cleared by a completed scan |

## Verification
The converter's done flag and the expiry of the timeout window can land in the same cycle. The bench provokes this by sweeping the converter's response delay across every value from one cycle to one past the window. It does this on both axes. At a delay equal to the window, the sample must be taken and the coordinate strobe must follow. One cycle later, the scan must abort with the error flag set and all electrodes floating.

// File: rtl/touch_scan_pkg.sv
package touch_scan_pkg;

  localparam int NUM_ELEC = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_START  = 2'd2,
    ST_WAIT   = 2'd3
  } scan_st_e;

  typedef enum logic {
    AX_HORZ = 1'b0,
    AX_VERT = 1'b1
  } axis_e;

  // electrode order: 0 X+, 1 X-, 2 Y+, 3 Y-
  function automatic logic [NUM_ELEC-1:0] axis_drive_en(axis_e a);
    return (a == AX_HORZ) ? 4'b0011 : 4'b1100;
  endfunction

  function automatic logic [NUM_ELEC-1:0] axis_drive_hi(axis_e a);
    return (a == AX_HORZ) ? 4'b0001 : 4'b0100;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int PERIOD_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(PERIOD_CYC - 1));

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  // R4: a period boundary lasts a single cycle
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import touch_scan_pkg::*;
#(
  parameter int SETTLE_CYC  = 100_000,
  parameter int TIMEOUT_CYC = 1_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_tick,
  input  logic                adc_done,
  output logic [NUM_ELEC-1:0] drv_en,
  output logic [NUM_ELEC-1:0] drv_hi,
  output logic                sense_on_xp,
  output logic                adc_start,
  output logic [1:0]          push_axis,
  output logic                scan_done,
  output logic                adc_err
);
  localparam int LIMIT = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CW    = $clog2(LIMIT + 1);

  scan_st_e      st_q, st_d;
  axis_e         ax_q, ax_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          accept, expire;

  assign accept = (st_q == ST_WAIT) && adc_done;
  assign expire = (st_q == ST_WAIT) && !adc_done && (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_comb begin
    st_d  = st_q;
    ax_d  = ax_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (scan_tick) begin
          st_d  = ST_SETTLE;
          ax_d  = AX_HORZ;
          cnt_d = '0;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == CW'(SETTLE_CYC - 1)) st_d = ST_START;
        else                              cnt_d = cnt_q + 1'b1;
      end
      ST_START: begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end
      ST_WAIT: begin
        if (accept) begin
          cnt_d = '0;
          if (ax_q == AX_HORZ) begin
            st_d = ST_SETTLE;
            ax_d = AX_VERT;
          end else begin
            st_d = ST_IDLE;
          end
        end else if (expire) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (expire)         err_d = 1'b1;
    else if (scan_done) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ax_q  <= AX_HORZ;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ax_q  <= ax_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign drv_en       = (st_q == ST_IDLE) ? '0 : axis_drive_en(ax_q);
  assign drv_hi       = (st_q == ST_IDLE) ? '0 : axis_drive_hi(ax_q);
  assign sense_on_xp  = (ax_q == AX_VERT);
  assign adc_start    = (st_q == ST_START);
  assign push_axis[0] = accept && (ax_q == AX_HORZ);
  assign push_axis[1] = accept && (ax_q == AX_VERT);
  assign scan_done    = push_axis[1];
  assign adc_err      = err_q;

  // R5: request lasts one cycle
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R3: request only after an unchanged, active drive
  assert_settled_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (drv_en != '0) && $stable(drv_en));
  // R3: drive held while waiting for the result
  assert_hold_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> $stable(drv_en) && $stable(drv_hi));
  // R1: horizontal pair levels and sense
  assert_horz_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 4'b0011) |-> (drv_hi == 4'b0001) && !sense_on_xp);
  // R2: vertical pair levels and sense
  assert_vert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 4'b1100) |-> (drv_hi == 4'b0100) && sense_on_xp);
  // R6: an abort leaves all electrodes floating
  assert_abort_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_err) |-> (drv_en == '0));

endmodule

// File: rtl/median3_filter.sv
module median3_filter #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] med_out
);
  logic [SAMPLE_W-1:0] h0_q, h1_q, med_q;
  logic [SAMPLE_W-1:0] h0_d, h1_d, med_d;
  logic [1:0]          fill_q, fill_d;
  logic [SAMPLE_W-1:0] lo01, hi01, mid;

  // median = max(min(a,b), min(max(a,b),c))
  always_comb begin
    lo01 = (sample < h0_q) ? sample : h0_q;
    hi01 = (sample < h0_q) ? h0_q : sample;
    mid  = (hi01 < h1_q) ? hi01 : h1_q;
    if (mid < lo01) mid = lo01;
  end

  always_comb begin
    h0_d   = h0_q;
    h1_d   = h1_q;
    med_d  = med_q;
    fill_d = fill_q;
    if (push) begin
      h0_d  = sample;
      h1_d  = h0_q;
      med_d = (fill_q < 2'd2) ? sample : mid;
      if (fill_q < 2'd2) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q   <= '0;
      h1_q   <= '0;
      med_q  <= '0;
      fill_q <= '0;
    end else begin
      h0_q   <= h0_d;
      h1_q   <= h1_d;
      med_q  <= med_d;
      fill_q <= fill_d;
    end
  end

  assign med_out = med_q;

  // R9: pass-through while the window is filling
  assert_warmup_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill_q < 2'd2) |=> (med_out == $past(sample)));
  // R8: the output is always one of the three windowed samples
  assert_median_member_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill_q == 2'd2) |=> (med_out == $past(sample) ||
                                  med_out == $past(h0_q) ||
                                  med_out == $past(h1_q)));

endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import touch_scan_pkg::*;
#(
  parameter int SAMPLE_W    = 10,
  parameter int SETTLE_CYC  = 100_000,
  parameter int PERIOD_CYC  = 2_000_000,
  parameter int TIMEOUT_CYC = 1_000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [3:0]          elec_drv_en,
  output logic [3:0]          elec_drv_hi,
  output logic                sense_on_xp,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic [SAMPLE_W-1:0] x_pos,
  output logic [SAMPLE_W-1:0] y_pos,
  output logic                pos_valid,
  output logic                adc_err
);
  localparam int NUM_AXES = 2;

  logic [1:0]          rst_sync_q;
  logic                rst_i_n;
  logic                tick;
  logic [1:0]          push_axis;
  logic                scan_done;
  logic                valid_q;
  logic [SAMPLE_W-1:0] med_ax [NUM_AXES];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  scan_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick)
  );

  scan_fsm #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .scan_tick   (tick),
    .adc_done    (adc_done),
    .drv_en      (elec_drv_en),
    .drv_hi      (elec_drv_hi),
    .sense_on_xp (sense_on_xp),
    .adc_start   (adc_start),
    .push_axis   (push_axis),
    .scan_done   (scan_done),
    .adc_err     (adc_err)
  );

  generate
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      median3_filter #(.SAMPLE_W(SAMPLE_W)) u_med (
        .clk     (clk),
        .rst_n   (rst_i_n),
        .push    (push_axis[a]),
        .sample  (adc_data),
        .med_out (med_ax[a])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) valid_q <= 1'b0;
    else          valid_q <= scan_done;
  end

  assign x_pos     = med_ax[0];
  assign y_pos     = med_ax[1];
  assign pos_valid = valid_q;

  // R10: strobe is one cycle wide
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    pos_valid |=> !pos_valid);
  // R11: strobe never coexists with the error flag
  assert_valid_clears_err_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    pos_valid |-> !adc_err);
  // R12: nothing is driven while the strobe is shown
  assert_float_after_scan_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    pos_valid |-> (elec_drv_en == '0));

endmodule

// File: tb/test_touch_scan_seq.sv
module test_touch_scan_seq;
  localparam int SETTLE = 5;
  localparam int PERIOD = 200;
  localparam int TMO    = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] drv_en, drv_hi;
  logic       sense;
  logic       adc_start;
  logic       adc_done;
  logic [9:0] adc_data;
  logic [9:0] x_pos, y_pos;
  logic       pos_valid;
  logic       adc_err;

  always #5 clk = ~clk;

  touch_scan_seq #(
    .SAMPLE_W(10), .SETTLE_CYC(SETTLE), .PERIOD_CYC(PERIOD), .TIMEOUT_CYC(TMO)
  ) i_touch_scan_seq (
    .clk(clk), .rst_n(rst_n), .elec_drv_en(drv_en), .elec_drv_hi(drv_hi),
    .sense_on_xp(sense), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .x_pos(x_pos), .y_pos(y_pos),
    .pos_valid(pos_valid), .adc_err(adc_err)
  );

  int nchk = 0, nfail = 0, cyc = 0, last_x = 0;
  int seen_valid = 0, exp_valid = 0;
  bit done_flag = 0, mon_on = 0;
  int hist [2][3];
  int fill [2];
  int expv [2];

  always @(posedge clk) cyc++;
  always @(negedge clk) if (mon_on && pos_valid) seen_valid++;

  task automatic check(input bit c, input string tag, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int med3(int a, int b, int c);
    int lo, hi, m;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    m  = (hi < c) ? hi : c;
    return (m < lo) ? lo : m;
  endfunction

  task automatic push_model(input int ax, input int v);
    hist[ax][2] = hist[ax][1];
    hist[ax][1] = hist[ax][0];
    hist[ax][0] = v;
    if (fill[ax] < 3) fill[ax]++;
    expv[ax] = (fill[ax] < 3) ? v : med3(hist[ax][0], hist[ax][1], hist[ax][2]);
  endtask

  task automatic conv(input int ax, input int k, input logic [9:0] v, output bit ok);
    int sc;
    bit first;
    sc = 0;
    first = 1;
    while (adc_start !== 1'b1) begin
      if (drv_en != 4'b0000) begin
        if (first && ax == 0) begin
          if (last_x > 0)
            check(((cyc - last_x) % PERIOD) == 0 && cyc > last_x, "R4", cyc - last_x, PERIOD);
          last_x = cyc;
        end
        first = 0;
        sc++;
      end
      @(negedge clk);
    end
    check(sc == SETTLE, "R3", sc, SETTLE);
    if (ax == 0)
      check({drv_en, drv_hi, sense} == 9'b0011_0001_0, "R1",
            int'({drv_en, drv_hi, sense}), int'(9'b0011_0001_0));
    else
      check({drv_en, drv_hi, sense} == 9'b1100_0100_1, "R2",
            int'({drv_en, drv_hi, sense}), int'(9'b1100_0100_1));
    ok = (k >= 1 && k <= TMO);
    @(negedge clk);
    check(adc_start == 1'b0, "R5", int'(adc_start), 0);
    if (k == 0) begin
      repeat (TMO) @(negedge clk);
    end else begin
      repeat (k - 1) @(negedge clk);
      adc_done = 1'b1;
      adc_data = v;
      @(negedge clk);
      adc_done = 1'b0;
    end
    if (!ok) check(adc_err == 1'b1 && drv_en == 4'b0000, "R6",
                   int'({adc_err, drv_en}), int'(5'b1_0000));
  endtask

  task automatic run_scan(input int kx, input int ky, input int vx, input int vy);
    bit okx, oky;
    string tx, ty;
    oky = 0;
    conv(0, kx, 10'(vx), okx);
    if (okx) push_model(0, vx);
    if (okx) begin
      conv(1, ky, 10'(vy), oky);
      if (oky) push_model(1, vy);
    end
    if (oky) begin
      exp_valid++;
      tx = (fill[0] < 3) ? "R9" : "R8";
      ty = (fill[1] < 3) ? "R9" : "R8";
      check(pos_valid == 1'b1, (kx == TMO || ky == TMO) ? "R7" : "R10", int'(pos_valid), 1);
      check(int'(x_pos) == expv[0], tx, int'(x_pos), expv[0]);
      check(int'(y_pos) == expv[1], ty, int'(y_pos), expv[1]);
      check(adc_err == 1'b0, "R11", int'(adc_err), 0);
      @(negedge clk);
      check(pos_valid == 1'b0, "R10", int'(pos_valid), 0);
      check(drv_en == 4'b0000, "R12", int'(drv_en), 0);
    end else begin
      check(pos_valid == 1'b0, "R6", int'(pos_valid), 0);
      check(adc_err == 1'b1, "R6", int'(adc_err), 1);
    end
  endtask

  task automatic stray_done();
    @(negedge clk);
    adc_done = 1'b1;
    adc_data = 10'h155;
    @(negedge clk);
    adc_done = 1'b0;
    check(pos_valid == 1'b0 && adc_start == 1'b0, "R5", int'({pos_valid, adc_start}), 0);
    check(int'(x_pos) == expv[0] && int'(y_pos) == expv[1], "R5", int'(x_pos), expv[0]);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 2; a++) begin
      fill[a] = 0;
      expv[a] = 0;
      for (int j = 0; j < 3; j++) hist[a][j] = 0;
    end
    rst_n = 1'b0;
    adc_done = 1'b0;
    adc_data = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(drv_en == 4'b0000 && adc_start == 1'b0, "R12", int'({drv_en, adc_start}), 0);
    check(pos_valid == 1'b0 && adc_err == 1'b0, "R12", int'({pos_valid, adc_err}), 0);
    check(x_pos == '0 && y_pos == '0, "R12", int'(x_pos), 0);
    rst_n = 1'b1;
    mon_on = 1;
    repeat (4) @(negedge clk);
    check(drv_en == 4'b0000, "R12", int'(drv_en), 0);

    for (int i = 0; i < 30; i++) begin
      int vx, vy, kx, ky;
      vx = (i * 97 + 13) % 1024;
      if (i % 5 == 3) vx = 1023;
      vy = 1023 - ((i * 61) % 1024);
      if (i % 7 == 2) vy = 0;
      kx = 1 + (i % TMO);
      ky = 1 + ((i * 3) % TMO);
      if (i == 10) kx = 0;        // no answer on the horizontal axis
      if (i == 15) ky = 0;        // no answer on the vertical axis
      if (i == 20) kx = TMO + 1;  // answer one cycle too late
      if (i == 22) ky = TMO + 1;
      run_scan(kx, ky, vx, vy);
      if (i == 5 || i == 25) stray_done();
    end

    repeat (2) @(negedge clk);
    check(seen_valid == exp_valid, "R10", seen_valid, exp_valid);
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule